// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and a 32K x 8 asynchronous static RAM. The host hands it one request at a time: an address, a read/write flag and, for a write, a data byte. The controller then drives the RAM's address, data and control pins through a fixed sequence of clock cycles. That sequence meets the RAM's pulse-width, setup, hold and recovery limits. The minimum times are given in nanoseconds, and the cycle counts are derived from them by rounding up against the clock period.

The RAM has a 15-bit address and an 8-bit data path. It also has four controls: an active-low select, an active-high enable, an active-low write strobe and an active-low output enable. The controller drives both select polarities together. It holds the RAM's output enable off around every write, so the shared data bus never has two drivers. Between consecutive writes it returns the write strobe to its inactive level for a recovery gap. A read keeps the output enable asserted for the access count. The byte is registered at the end of that count and returned to the host with a one-cycle valid pulse.

The data bus is presented as three plain signals: a drive value, a drive enable and a sampled input. The pad or tristate buffer joins them outside the block.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and after reset, with no request pending, the pins are as follows. `ram_cs_n`=1, `ram_ce`=0, `ram_we_n`=1 and `ram_oe_n`=1. `ram_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken only in a cycle where `req_ready` is 1, which happens only while the controller is idle. A request presented while `req_ready` is 0 has no effect. A write keeps `req_ready` low for 1+WP+REC cycles after acceptance, and a read keeps it low for RD cycles. The defaults are 100 MHz, WP=2, REC=1 and RD=3.
- R3: For a write, select and enable go active one cycle before `ram_we_n` falls. `ram_we_n` then stays low for exactly WP cycles. `ram_we_n` is never low unless select and enable are both active. `ram_addr` does not change while `ram_we_n` is low.
- R4: `ram_dq_oe` is 1 in the setup cycle, throughout the write pulse and in the first cycle after it. `ram_dq_out` holds the request's byte and does not change during the pulse.
- R5: After the write pulse, `ram_we_n` stays high with the chip still selected for exactly REC cycles. The controller then deselects.
- R6: `ram_oe_n` is 1 in every cycle where `ram_dq_oe` is 1. It is also 1 in the cycle after `ram_we_n` rises.
- R7: For a read, `ram_oe_n` is low for exactly RD consecutive cycles, with select active and `ram_we_n` high. `ram_dq_in` is sampled at the clock edge that ends the last of those cycles.
- R8: `rsp_valid` is a single-cycle pulse in the first idle cycle after a read. It carries the captured byte on `rsp_rdata`, and a write never produces it.
- R9: Data written to any address is returned by a later read of that address. This holds across the whole 15-bit range, including the first and last locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe for returned read data |
| rsp_rdata | output | 8 | Returned read byte |
| ram_addr | output | 15 | RAM address pins |
| ram_dq_out | output | 8 | Value driven onto the RAM data bus |
| ram_dq_oe | output | 1 | Drive enable for the RAM data bus |
| ram_dq_in | input | 8 | Value sampled from the RAM data bus |
| ram_cs_n | output | 1 | Active-low chip select |
| ram_ce | output | 1 | Active-high chip enable |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low RAM output enable |

## Verification
Every RAM pin is a flop decoded from the next sequencer state. A wrong state or a wrong count therefore shows on the pins in the very next cycle: a write strobe one cycle too long or too short, a missing recovery cycle, or an output enable overlapping the controller's own drive. The bench model of the RAM hands out valid data only after the full access count. A read sampled one cycle early returns a junk byte on `rsp_rdata` at the end of that same transaction. A lost or misplaced write shows up when that address is read back later in the sweep.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WREC = 3'd3,
    ST_RACC = 3'd4
  } seq_state_t;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int t_ns, input int period_ns);
    int r;
    r = (t_ns + period_ns - 1) / period_ns;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_rst_sync.sv
module sram_ctrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // A decrement is never requested from zero.
  assert_timer_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 1,
  parameter int RD_CYC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic cs_n,
  output logic ce,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);

  localparam int MAXC = max3(WP_CYC, REC_CYC, RD_CYC);
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);

  seq_state_t    state_q, state_d;
  logic          t_load, t_dec, t_zero;
  logic [CW-1:0] t_val;
  logic          cs_n_d, ce_d, we_n_d, oe_n_d, dq_oe_d;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .zero     (t_zero)
  );

  // Next-state and timer control
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    t_dec   = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            state_d = ST_WSET;
          end else begin
            state_d = ST_RACC;
            t_load  = 1'b1;
            t_val   = RD_LD;
          end
        end
      end
      ST_WSET: begin
        state_d = ST_WPUL;
        t_load  = 1'b1;
        t_val   = WP_LD;
      end
      ST_WPUL: begin
        if (t_zero) begin
          state_d = ST_WREC;
          t_load  = 1'b1;
          t_val   = REC_LD;
        end else begin
          t_dec = 1'b1;
        end
      end
      ST_WREC: begin
        if (t_zero) state_d = ST_IDLE;
        else        t_dec   = 1'b1;
      end
      ST_RACC: begin
        if (t_zero) begin
          state_d = ST_IDLE;
          capture = 1'b1;
        end else begin
          t_dec = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  // Pin levels decoded from the state being entered, so every pin is a flop.
  always_comb begin
    cs_n_d  = (state_d == ST_IDLE);
    ce_d    = (state_d != ST_IDLE);
    we_n_d  = (state_d != ST_WPUL);
    oe_n_d  = (state_d != ST_RACC);
    dq_oe_d = (state_d == ST_WSET) || (state_d == ST_WPUL) ||
              ((state_q == ST_WPUL) && (state_d == ST_WREC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n    <= 1'b1;
      ce      <= 1'b0;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n    <= cs_n_d;
      ce      <= ce_d;
      we_n    <= we_n_d;
      oe_n    <= oe_n_d;
      dq_oe   <= dq_oe_d;
    end
  end

  assert_we_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && ce));

  assert_pulse_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  assert_oe_off_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> oe_n);

  assert_read_not_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !cs_n));

  assert_ready_means_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && we_n && oe_n));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ram_dq_in,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dq_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d, rdata_d;

  always_comb begin
    addr_d  = accept  ? req_addr  : ram_addr;
    wdata_d = accept  ? req_wdata : ram_dq_out;
    rdata_d = capture ? ram_dq_in : rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
      rsp_rdata  <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      ram_addr   <= addr_d;
      ram_dq_out <= wdata_d;
      rsp_rdata  <= rdata_d;
      rsp_valid  <= capture;
    end
  end

  assert_rsp_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(rsp_rdata));

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 15,
  parameter int DW     = 8,
  parameter int CLK_NS = 10,
  parameter int WP_NS  = 20,
  parameter int REC_NS = 5,
  parameter int RD_NS  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in,
  output logic          ram_cs_n,
  output logic          ram_ce,
  output logic          ram_we_n,
  output logic          ram_oe_n
);

  localparam int WP_CYC  = ns_to_cycles(WP_NS,  CLK_NS);
  localparam int REC_CYC = ns_to_cycles(REC_NS, CLK_NS);
  localparam int RD_CYC  = ns_to_cycles(RD_NS,  CLK_NS);

  logic rst_n_int;
  logic accept, capture;

  sram_ctrl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sram_ctrl_fsm #(
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .RD_CYC  (RD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .cs_n      (ram_cs_n),
    .ce        (ram_ce),
    .we_n      (ram_we_n),
    .oe_n      (ram_oe_n),
    .dq_oe     (ram_dq_oe)
  );

  sram_ctrl_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .ram_dq_in  (ram_dq_in),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // Address and write data held steady across the strobe, which the sequencer
  // and the datapath register separately.
  assert_addr_hold_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ram_we_n |-> $stable(ram_addr));

  assert_data_hold_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ram_we_n |-> $stable(ram_dq_out));

  assert_no_rsp_while_writing_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ram_we_n |-> !rsp_valid);

endmodule

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;

  localparam int WP  = 2;
  localparam int REC = 1;
  localparam int RD  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] ram_addr;
  logic [7:0]  ram_dq_out;
  logic        ram_dq_oe, ram_cs_n, ram_ce, ram_we_n, ram_oe_n;
  logic [7:0]  ram_dq_in = 8'h00;

  int n_vec = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  logic [7:0] model_mem [int];
  logic [7:0] expect_mem [int];

  always #5 clk = ~clk;

  sram_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in), .ram_cs_n(ram_cs_n), .ram_ce(ram_ce),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // ---------------- RAM model -----------------
  logic rd_cond, wr_act;
  int   rd_age;
  assign rd_cond = !ram_cs_n && ram_ce && ram_we_n && !ram_oe_n;
  assign wr_act  = !ram_cs_n && ram_ce && !ram_we_n;

  always @(posedge clk) begin
    if (!rd_cond) rd_age <= 0;
    else          rd_age <= rd_age + 1;
  end

  // ---------------- Pin monitor -----------------
  logic        p_we_n = 1'b1, p_cs_n = 1'b1, p_dq_oe = 1'b0, p_act = 1'b0;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  int we_run = 0, oe_run = 0, rec_run = 0;
  bit in_rec = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      // bus ownership
      if (ram_dq_oe || !ram_oe_n)
        chk(!(ram_dq_oe && !ram_oe_n), "R6 two drivers on data bus", {ram_dq_oe, ram_oe_n}, 2'b11);
      // recovery gap
      if (in_rec) begin
        if (ram_cs_n) begin
          chk(rec_run == REC, "R5 recovery length", rec_run, REC);
          in_rec = 1'b0;
        end else if (ram_we_n) rec_run++;
      end
      // write strobe
      if (!ram_we_n) begin
        if (p_we_n)
          chk(!p_cs_n && p_dq_oe, "R3/R4 setup cycle before strobe", {p_cs_n, p_dq_oe}, 2'b01);
        else
          chk(ram_dq_out == p_dq, "R4 data steady in pulse", ram_dq_out, p_dq);
        chk(ram_addr == p_addr, "R3 address steady in pulse", ram_addr, p_addr);
        chk(!ram_cs_n && ram_ce, "R3 strobe while selected", {ram_cs_n, ram_ce}, 2'b01);
        we_run++;
      end else if (we_run != 0) begin
        chk(we_run == WP, "R3 strobe width", we_run, WP);
        chk(ram_oe_n == 1'b1, "R6 oe off after strobe", ram_oe_n, 1);
        chk(ram_dq_oe == 1'b1, "R4 drive held after strobe", ram_dq_oe, 1);
        we_run  = 0;
        in_rec  = 1'b1;
        rec_run = 1;
      end
      // read window
      if (!ram_oe_n) begin
        chk(ram_we_n && !ram_cs_n && ram_ce, "R7 read controls", {ram_we_n, ram_cs_n, ram_ce}, 3'b101);
        oe_run++;
      end else if (oe_run != 0) begin
        chk(oe_run == RD, "R7 read window length", oe_run, RD);
        oe_run = 0;
      end
      // model write on trailing edge of the combined condition
      if (p_act && !wr_act)
        model_mem[int'(p_addr)] = p_dq_oe ? p_dq : 8'hEE;
    end
    // model read data: valid only after the full access time
    if (rd_cond && rd_age >= RD - 1)
      ram_dq_in = model_mem.exists(int'(ram_addr)) ? model_mem[int'(ram_addr)] : 8'h00;
    else
      ram_dq_in = 8'h5A ^ ram_addr[7:0];
    p_we_n  = ram_we_n;
    p_cs_n  = ram_cs_n;
    p_dq_oe = ram_dq_oe;
    p_act   = wr_act;
    p_addr  = ram_addr;
    p_dq    = ram_dq_out;
  end

  // ---------------- Host tasks -----------------
  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    int busy;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin
      chk(!rsp_valid, "R8 no response for write", rsp_valid, 0);
      busy++;
      @(negedge clk);
    end
    chk(busy == 1 + WP + REC, "R2 write busy cycles", busy, 1 + WP + REC);
    chk(!rsp_valid, "R8 no response after write", rsp_valid, 0);
    expect_mem[int'(a)] = d;
  endtask

  // poke: present a write request while busy to show it is ignored
  task automatic do_read(input logic [14:0] a, input bit poke, input logic [14:0] pa);
    int busy;
    logic [7:0] ev;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin
      if (poke && busy == 0) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = pa; req_wdata = 8'hC3;
      end else begin
        req_valid = 1'b0;
      end
      busy++;
      @(negedge clk);
      if (poke && busy == RD - 1) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk(busy == RD, "R2 read busy cycles", busy, RD);
    ev = expect_mem.exists(int'(a)) ? expect_mem[int'(a)] : 8'h00;
    chk(rsp_valid == 1'b1, "R8 response strobe", rsp_valid, 1);
    chk(rsp_rdata == ev, "R9 read-back data", rsp_rdata, ev);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 strobe one cycle", rsp_valid, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_vec++;
      $display("FAIL watchdog: run hung, actual=0 expected=1");
      summary();
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk({ram_cs_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe} == 5'b10110,
        "R1 pins in reset", {ram_cs_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    chk({ram_cs_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe} == 5'b10110,
        "R1 pins idle", {ram_cs_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
    chk(req_ready && !rsp_valid, "R1 ready idle", {req_ready, rsp_valid}, 2'b10);

    // Sweep a block of low addresses, then the range edges (R9)
    for (int a = 0; a < 128; a++) do_write(15'(a), 8'((a * 37 + 11) & 8'hFF));
    do_write(15'h7FFF, 8'hFF);
    do_write(15'h4000, 8'h80);
    do_write(15'h2AAA, 8'h55);
    do_write(15'h5555, 8'hAA);
    for (int a = 0; a < 128; a++) do_read(15'(a), 1'b0, '0);
    do_read(15'h7FFF, 1'b0, '0);
    do_read(15'h4000, 1'b0, '0);
    do_read(15'h2AAA, 1'b0, '0);
    do_read(15'h5555, 1'b0, '0);

    // Overwrite and alternate write/read on the same location
    for (int k = 0; k < 16; k++) begin
      do_write(15'(k * 1031), 8'(k ^ 8'h3C));
      do_read(15'(k * 1031), 1'b0, '0);
    end

    // R2: a write presented while busy is ignored; target keeps old byte
    do_write(15'h0100, 8'h12);
    do_read(15'h0005, 1'b1, 15'h0100);
    do_read(15'h0100, 1'b0, '0);

    done = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule